// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside an 8-bit CPU core. It gathers five interrupt requests and picks the most urgent one that is allowed to run. It then presents a 16-bit service address for that request. The core sees `irq_o` together with `vec_o`. It pulses `ack_i` in the cycle it takes the interrupt, and the controller then updates its own state.

One request is non-maskable and always wins. Three requests have fixed vectors and individual mask bits. Two of these are level-sensitive. The third is captured on a rising edge and held in a latch. The lowest request is non-vectored: the requesting device drives a restart number onto `ack_byte_i`, and the vector is that number times eight.

The core configures the block by writing a packed configuration byte. That byte sets the masks, clears the edge latch and drives a one-bit serial output. The core reads back a packed status byte holding the masks, the enable flag, the pending bits and a serial input line. A global enable flag gates every maskable request. The core sets and clears it with dedicated strobes, and the block clears it itself whenever a maskable request is accepted.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the three mask bits are 1, the enable flag is 0, the edge latch is 0 and `ser_out_o` is 0, so `status_o` reads 8'h07 with `ser_in_i` low and `irq_o` is 0.
- R2: A configuration write replaces the masks with data bits 2:0 (bit 0 low level, bit 1 high level, bit 2 edge; 1 = masked) only when data bit 3 is 1; with bit 3 at 0 the masks keep their value.
- R3: A configuration write with data bit 4 set clears the edge latch; a rising edge on `edge_req_i` in the same cycle leaves the latch set.
- R4: `ser_out_o` takes data bit 7 of a configuration write only when data bit 6 of that write is 1; otherwise it holds.
- R5: `status_o` bits 2:0 give the masks, bit 3 the enable flag, bit 4 the raw `lvl_lo_req_i`, bit 5 the raw `lvl_hi_req_i`, bit 6 the edge latch and bit 7 `ser_in_i`; pending bits show regardless of masks.
- R6: While `nmi_req_i` is high, `irq_o` is 1 and `vec_o` is 16'h0024 whatever the masks and enable flag are; accepting it leaves the enable flag unchanged.
- R7: When several requests are eligible the grant order is non-maskable, edge, high level, low level, external.
- R8: The vectors are 16'h003C for the edge request, 16'h0034 for the high level and 16'h002C for the low level; the external request vectors to `ack_byte_i` times 8.
- R9: A maskable request is eligible only when the enable flag is 1 and its own mask bit is 0; the external request needs only the enable flag.
- R10: `ie_set_i` sets the enable flag; `ie_clr_i`, or acceptance of any maskable request, clears it and wins over `ie_set_i` in the same cycle.
- R11: A rising edge on `edge_req_i` sets the edge latch, which stays set after the input falls until the edge request is accepted or cleared by R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req_i | input | 1 | Non-maskable request, level |
| edge_req_i | input | 1 | Maskable request, rising-edge captured |
| lvl_hi_req_i | input | 1 | Maskable request, level, higher of the two |
| lvl_lo_req_i | input | 1 | Maskable request, level, lower of the two |
| ext_req_i | input | 1 | Non-vectored request, level |
| ack_byte_i | input | 8 | Restart number supplied for the external request |
| ack_i | input | 1 | Core accepts the current grant this cycle |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 8 | Configuration byte |
| ie_set_i | input | 1 | Set the enable flag |
| ie_clr_i | input | 1 | Clear the enable flag |
| ser_in_i | input | 1 | Serial input line |
| ser_out_o | output | 1 | Serial output latch |
| status_o | output | 8 | Packed status byte |
| irq_o | output | 1 | A request is granted |
| vec_o | output | 16 | Service address of the grant |

## Verification
Two updates can land on the edge latch in the same cycle: a fresh rising edge on the request line, and a clear from either a configuration write with bit 4 or acceptance of the edge request. The bench holds the line low for a cycle and then raises it in the very cycle the clearing write is presented. The latch must read set in the next status byte, and a second clear with the line held high must then empty it. The enable flag gets the same treatment: a set strobe coincides with a clear strobe, and the flag must end cleared.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter logic [15:0] NMI_VEC  = 16'h0024,
  parameter logic [15:0] EDGE_VEC = 16'h003C,
  parameter logic [15:0] HI_VEC   = 16'h0034,
  parameter logic [15:0] LO_VEC   = 16'h002C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_req_i,
  input  logic        edge_req_i,
  input  logic        lvl_hi_req_i,
  input  logic        lvl_lo_req_i,
  input  logic        ext_req_i,
  input  logic [7:0]  ack_byte_i,
  input  logic        ack_i,
  input  logic        cfg_wr_i,
  input  logic [7:0]  cfg_data_i,
  input  logic        ie_set_i,
  input  logic        ie_clr_i,
  input  logic        ser_in_i,
  output logic        ser_out_o,
  output logic [7:0]  status_o,
  output logic        irq_o,
  output logic [15:0] vec_o
);

  logic [2:0] mask_q;
  logic       ie_q, edge_q, edge_d, sout_q;
  logic       take_mask, take_edge;
  logic       unused_bit;

  assign unused_bit = cfg_data_i[5];

  wire       edge_rise = edge_req_i & ~edge_d;
  wire [2:0] avail     = ~mask_q & {edge_q, lvl_hi_req_i, lvl_lo_req_i} & {3{ie_q}};
  wire       ext_av    = ie_q & ext_req_i;

  always_comb begin
    irq_o     = 1'b1;
    vec_o     = NMI_VEC;
    take_mask = 1'b0;
    take_edge = 1'b0;
    if (nmi_req_i) begin
      vec_o = NMI_VEC;
    end else if (avail[2]) begin
      vec_o = EDGE_VEC;
      take_mask = ack_i;
      take_edge = ack_i;
    end else if (avail[1]) begin
      vec_o = HI_VEC;
      take_mask = ack_i;
    end else if (avail[0]) begin
      vec_o = LO_VEC;
      take_mask = ack_i;
    end else if (ext_av) begin
      vec_o = {5'b0, ack_byte_i, 3'b000};
      take_mask = ack_i;
    end else begin
      irq_o = 1'b0;
      vec_o = 16'h0000;
    end
  end

  assign status_o  = {ser_in_i, edge_q, lvl_hi_req_i, lvl_lo_req_i, ie_q, mask_q};
  assign ser_out_o = sout_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= 3'b111;
      ie_q   <= 1'b0;
      edge_q <= 1'b0;
      edge_d <= 1'b0;
      sout_q <= 1'b0;
    end else begin
      edge_d <= edge_req_i;
      if (cfg_wr_i && cfg_data_i[3]) mask_q <= cfg_data_i[2:0];
      if (cfg_wr_i && cfg_data_i[6]) sout_q <= cfg_data_i[7];
      if (edge_rise)
        edge_q <= 1'b1;
      else if (take_edge || (cfg_wr_i && cfg_data_i[4]))
        edge_q <= 1'b0;
      if (ie_clr_i || take_mask)
        ie_q <= 1'b0;
      else if (ie_set_i)
        ie_q <= 1'b1;
    end
  end

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        nmi_req_i,
  input logic        edge_req_i,
  input logic        ack_i,
  input logic        cfg_wr_i,
  input logic [7:0]  cfg_data_i,
  input logic        ser_out_o,
  input logic [7:0]  status_o,
  input logic        irq_o,
  input logic [15:0] vec_o
);

  // R6
  nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req_i |-> (irq_o && vec_o == 16'h0024));

  // R9
  gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_o[3] && !nmi_req_i) |-> !irq_o);

  // R10
  accept_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !nmi_req_i) |=> !status_o[3]);

  // R11
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_req_i) |=> status_o[6]);

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && !cfg_data_i[3]) |=> $stable(status_o[2:0]));

  // R4
  sout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && !cfg_data_i[6]) |=> $stable(ser_out_o));

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (.*);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi = 0, edg = 0, hi = 0, lo = 0, ext = 0, ack = 0;
  logic [7:0] abyte = 0, cdata = 0;
  logic cwr = 0, ies = 0, iec = 0, sin = 0;
  logic sout, irq;
  logic [7:0] stat;
  logic [15:0] vec;
  int nvec = 0, nbad = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nmi_req_i(nmi), .edge_req_i(edg),
    .lvl_hi_req_i(hi), .lvl_lo_req_i(lo), .ext_req_i(ext),
    .ack_byte_i(abyte), .ack_i(ack), .cfg_wr_i(cwr), .cfg_data_i(cdata),
    .ie_set_i(ies), .ie_clr_i(iec), .ser_in_i(sin),
    .ser_out_o(sout), .status_o(stat), .irq_o(irq), .vec_o(vec)
  );

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] d);
    cwr = 1; cdata = d; tick(); cwr = 0; cdata = 0;
  endtask

  task automatic pulse_ie(input logic s, input logic c);
    ies = s; iec = c; tick(); ies = 0; iec = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 status", {8'h0, stat}, 16'h0007);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 ser_out", {15'h0, sout}, 16'h0);
  endtask

  task automatic t_masks();
    pulse_ie(1, 0);
    cfg(8'h0A);
    chk("R2 masks written", {8'h0, stat}, 16'h000A);
    cfg(8'h05);
    chk("R2 masks held", {8'h0, stat}, 16'h000A);
  endtask

  task automatic t_serial();
    cfg(8'h80);
    chk("R4 no enable", {15'h0, sout}, 16'h0);
    cfg(8'hC0);
    chk("R4 set", {15'h0, sout}, 16'h1);
    cfg(8'h40);
    chk("R4 clear", {15'h0, sout}, 16'h0);
    sin = 1; #1;
    chk("R5 ser_in bit", {15'h0, stat[7]}, 16'h1);
    sin = 0;
  endtask

  task automatic t_levels();
    hi = 1; #1;
    chk("R9 masked high", {15'h0, irq}, 16'h0);
    chk("R5 raw pending", {8'h0, stat}, 16'h002A);
    lo = 1; #1;
    chk("R8 low vector", vec, 16'h002C);
    ext = 1; abyte = 8'h05; #1;
    chk("R7 low over ext", vec, 16'h002C);
    lo = 0; #1;
    chk("R8 ext vector", vec, 16'h0028);
    ack = 1; tick(); ack = 0;
    chk("R10 accept clears ie", {15'h0, stat[3]}, 16'h0);
    chk("R9 ie off", {15'h0, irq}, 16'h0);
    hi = 0; ext = 0;
  endtask

  task automatic t_edge();
    pulse_ie(1, 0);
    cfg(8'h08);
    edg = 1; tick(); edg = 0; tick();
    chk("R11 latch held", {15'h0, stat[6]}, 16'h1);
    chk("R8 edge vector", vec, 16'h003C);
    hi = 1; #1;
    chk("R7 edge over high", vec, 16'h003C);
    ack = 1; tick(); ack = 0;
    chk("R11 accept clears latch", {15'h0, stat[6]}, 16'h0);
    chk("R10 ie cleared", {15'h0, stat[3]}, 16'h0);
    pulse_ie(1, 0);
    chk("R8 high vector", vec, 16'h0034);
    hi = 0;
  endtask

  task automatic t_race();
    edg = 1; tick(); edg = 0; tick();
    cfg(8'h10);
    chk("R3 clear", {15'h0, stat[6]}, 16'h0);
    edg = 1; cfg(8'h10);
    chk("R3 edge wins", {15'h0, stat[6]}, 16'h1);
    cfg(8'h10);
    chk("R3 clear high line", {15'h0, stat[6]}, 16'h0);
    edg = 0; tick();
  endtask

  task automatic t_nmi();
    cfg(8'h0F);
    edg = 1; tick(); edg = 0;
    nmi = 1; #1;
    chk("R6 nmi vector", vec, 16'h0024);
    chk("R6 nmi irq", {15'h0, irq}, 16'h1);
    ack = 1; tick(); ack = 0;
    chk("R6 ie kept", {15'h0, stat[3]}, 16'h1);
    nmi = 0;
    cfg(8'h08); #1;
    chk("R8 edge after unmask", vec, 16'h003C);
    pulse_ie(1, 1);
    chk("R10 clear wins", {15'h0, stat[3]}, 16'h0);
    chk("R9 no grant", {15'h0, irq}, 16'h0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    t_reset();
    t_masks();
    t_serial();
    t_levels();
    t_edge();
    t_race();
    t_nmi();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule